// File: doc/BRIEF.md
# Serial Flash Sector Erase Command Slave

This block is the device side of a serial flash that handles one erase command. It listens on an SPI mode-0 link (active-low select, serial clock, data in, data out), sampled by the block's own system clock. It recognises three instructions. The first sets the write-enable latch. The second returns the status byte and can be repeated without limit. The third erases a 4 KB sector named by a 24-bit address, sent most significant bit first.

An erase runs only if three conditions hold. Select must be released exactly after the 32nd bit. The write-enable latch must be set. The addressed sector must lie outside the region selected by the protection inputs. The erase then runs for a fixed number of clock cycles. During that time the busy bit reads 1, and status reads are the only instruction served. When the timer expires, the modelled bytes of the sector become FFh, busy drops and the write-enable latch clears.

The storage is a small behavioural model. It holds `1<<SECT_W` sectors, with sector index A[12+SECT_W-1:12], and `1<<KEEP_W` bytes per sector. Upper address bits alias onto these sectors. A side port reads any modelled byte so that results can be seen.

Top module: `flash_sector_erase`

## Requirements
- R1: After reset the status byte is 00h. Modelled byte i, where i = {sector, offset}, holds {1'b0, (5*i+3) mod 128}.
- R2: Opcode 06h with select released after exactly 8 bits sets the write-enable latch. The same opcode with any other bit count leaves the latch unchanged.
- R3: After opcode 05h the device shifts out the status byte MSB first on data out. Bit 0 is busy, bit 1 is the write-enable latch and bits 7:2 are 0. The byte repeats for as long as clocks continue. Data out changes only after a falling serial clock, or when select is high.
- R4: Opcode 20h followed by a 24-bit address, released after exactly 32 bits, with the latch set and the sector unprotected, erases sector A[12+SECT_W-1:12]. At the end every modelled byte of that sector reads FFh and all other bytes are unchanged.
- R5: An erase command released after any bit count other than 32 has no effect on memory, busy or the latch.
- R6: An erase command issued while the write-enable latch is 0 is ignored.
- R7: Let the protection level be lvl (3 bits). lvl=0 protects nothing. Otherwise span = min(2^(lvl-1), number of sectors). With the bottom select at 1, sectors below span are protected. With the bottom select at 0, the top span sectors are protected. An erase of a protected sector is refused.
- R8: Busy stays high for exactly ERASE_CYCLES clock cycles after the select release that starts the erase, and status reads return busy=1 during that time.
- R9: The write-enable latch clears when the erase finishes. A refused erase leaves the latch as it was.
- R10: While busy, every instruction except a status read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial link |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock, mode 0 |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| prot_lvl_i | input | 3 | Protection level |
| prot_bot_i | input | 1 | 1: protected region at bottom, 0: at top |
| peek_sect_i | input | SECT_W | Sector of the byte to observe |
| peek_off_i | input | KEEP_W | Offset of the byte to observe |
| peek_data_o | output | 8 | Observed byte |

## Verification
On every cycle, the assertions check that:
- busy lasts exactly the configured number of cycles;
- the latch is clear whenever busy falls;
- an erase never starts without the latch set, or on a protected sector;
- the latch never rises while busy;
- data out moves only after a falling clock.

The bench scenarios are needed for the end-to-end results. These are that the right sector is filled with FFh while its neighbours are left alone, and that the status bytes read back are correct. They also cover commands that fail on bit count, which must leave everything unchanged. A sweep over every protection level, both region sides and every sector checks the refusal rule against an arithmetic model.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam int unsigned ADDR_W   = 24;
  localparam int unsigned OP_BITS  = 8;
  localparam int unsigned CMD_BITS = OP_BITS + ADDR_W;
  localparam int unsigned NB_W     = $clog2(CMD_BITS + 2);
  localparam int unsigned SECT_LSB = 12;

  typedef enum logic [7:0] {
    OP_STATUS  = 8'h05,
    OP_WR_EN   = 8'h06,
    OP_ERASE4K = 8'h20
  } opcode_e;

  function automatic logic sect_guarded(input int unsigned sect, input int unsigned n_sect,
                                        input logic [2:0] lvl, input logic bot);
    int unsigned span;
    span = (lvl == 3'd0) ? 32'd0 : (32'd1 << (lvl - 3'd1));
    if (span > n_sect) span = n_sect;
    if (bot) return sect < span;
    return sect >= (n_sect - span);
  endfunction

  function automatic logic [7:0] fill_byte(input int unsigned idx);
    logic [31:0] v;
    v = idx * 32'd5 + 32'd3;
    return {1'b0, v[6:0]};
  endfunction
endpackage

// File: rtl/fse_spi_port.sv
module fse_spi_port
  import fse_pkg::*;
#(
  parameter int unsigned SECT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [7:0]        status_i,
  output logic              cs_rise_o,
  output logic [NB_W-1:0]   nbits_o,
  output logic [7:0]        op_o,
  output logic [SECT_W-1:0] sect_o,
  output logic              sdo_o
);
  localparam int unsigned SH_W = SECT_LSB + SECT_W;
  localparam logic [NB_W-1:0] NB_MAX = NB_W'(CMD_BITS + 1);

  logic            sck_q, cs_q;
  logic [NB_W-1:0] nbits_q;
  logic [2:0]      ph_q;
  logic [SH_W-1:0] sh_q;
  logic [7:0]      op_q;
  logic            rise, fall;

  assign rise = ~cs_ni & sck_i & ~sck_q;
  assign fall = ~cs_ni & ~sck_i & sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      nbits_q <= '0;
      ph_q    <= '0;
      sh_q    <= '0;
      op_q    <= '0;
      sdo_o   <= 1'b0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_ni) begin
        nbits_q <= '0;
        ph_q    <= '0;
        op_q    <= '0;
        sdo_o   <= 1'b0;
      end else begin
        if (rise) begin
          sh_q <= {sh_q[SH_W-2:0], sdi_i};
          ph_q <= ph_q + 3'd1;
          if (nbits_q != NB_MAX) nbits_q <= nbits_q + 1'b1;
          if (nbits_q == NB_W'(OP_BITS - 1)) op_q <= {sh_q[6:0], sdi_i};
        end
        // status shifts out MSB first, one bit per falling edge
        if (fall && op_q == OP_STATUS && nbits_q >= NB_W'(OP_BITS))
          sdo_o <= status_i[~ph_q];
      end
    end
  end

  assign cs_rise_o = cs_ni & ~cs_q;
  assign nbits_o   = nbits_q;
  assign op_o      = op_q;
  assign sect_o    = sh_q[SECT_LSB +: SECT_W];
endmodule

// File: rtl/fse_cmd_ctrl.sv
module fse_cmd_ctrl
  import fse_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 5000,
  parameter int unsigned SECT_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_rise_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic [7:0]        op_i,
  input  logic [SECT_W-1:0] sect_req_i,
  input  logic [2:0]        prot_lvl_i,
  input  logic              prot_bot_i,
  output logic              busy_o,
  output logic              wel_o,
  output logic              erase_go_o,
  output logic [SECT_W-1:0] sect_o
);
  localparam int unsigned N_SECT = 1 << SECT_W;
  localparam int unsigned TMR_W  = $clog2(ERASE_CYCLES + 1);

  logic             busy_q, wel_q;
  logic [TMR_W-1:0] tmr_q;
  logic [SECT_W-1:0] sect_q;
  logic guarded, wr_en_ok, erase_ok, erase_go;

  assign guarded  = sect_guarded(32'(sect_req_i), N_SECT, prot_lvl_i, prot_bot_i);
  assign wr_en_ok = cs_rise_i && !busy_q && nbits_i == NB_W'(OP_BITS) && op_i == OP_WR_EN;
  assign erase_ok = cs_rise_i && !busy_q && nbits_i == NB_W'(CMD_BITS) && op_i == OP_ERASE4K
                    && wel_q && !guarded;
  assign erase_go = busy_q && tmr_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      tmr_q  <= '0;
      sect_q <= '0;
    end else begin
      if (erase_go) begin
        busy_q <= 1'b0;
        wel_q  <= 1'b0;
      end else if (erase_ok) begin
        busy_q <= 1'b1;
        tmr_q  <= TMR_W'(ERASE_CYCLES - 1);
        sect_q <= sect_req_i;
      end else if (busy_q) begin
        tmr_q <= tmr_q - 1'b1;
      end
      if (wr_en_ok) wel_q <= 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign wel_o      = wel_q;
  assign erase_go_o = erase_go;
  assign sect_o     = sect_q;
endmodule

// File: rtl/fse_sect_mem.sv
module fse_sect_mem
  import fse_pkg::*;
#(
  parameter int unsigned SECT_W = 3,
  parameter int unsigned KEEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_go_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic [SECT_W-1:0] peek_sect_i,
  input  logic [KEEP_W-1:0] peek_off_i,
  output logic [7:0]        peek_data_o
);
  localparam int unsigned KEEP_N  = 1 << KEEP_W;
  localparam int unsigned N_BYTES = 1 << (SECT_W + KEEP_W);

  logic [N_BYTES-1:0][7:0] bytes_w;

  for (genvar gi = 0; gi < N_BYTES; gi++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= fill_byte(gi);
      else if (erase_go_i && sect_i == SECT_W'(gi / KEEP_N)) byte_q <= 8'hFF;
    end
    assign bytes_w[gi] = byte_q;
  end

  assign peek_data_o = bytes_w[{peek_sect_i, peek_off_i}];
endmodule

// File: rtl/flash_sector_erase.sv
module flash_sector_erase
  import fse_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 5000,
  parameter int unsigned SECT_W       = 3,
  parameter int unsigned KEEP_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [2:0]        prot_lvl_i,
  input  logic              prot_bot_i,
  input  logic [SECT_W-1:0] peek_sect_i,
  input  logic [KEEP_W-1:0] peek_off_i,
  output logic [7:0]        peek_data_o
);
  logic              cs_rise, busy, wel, erase_go;
  logic [NB_W-1:0]   nbits;
  logic [7:0]        op, status;
  logic [SECT_W-1:0] sect_req, sect;

  assign status = {6'b0, wel, busy};

  fse_spi_port #(.SECT_W(SECT_W)) u_port (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .sdi_i,
    .status_i (status),
    .cs_rise_o(cs_rise),
    .nbits_o  (nbits),
    .op_o     (op),
    .sect_o   (sect_req),
    .sdo_o
  );

  fse_cmd_ctrl #(.ERASE_CYCLES(ERASE_CYCLES), .SECT_W(SECT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_rise_i (cs_rise),
    .nbits_i   (nbits),
    .op_i      (op),
    .sect_req_i(sect_req),
    .prot_lvl_i,
    .prot_bot_i,
    .busy_o    (busy),
    .wel_o     (wel),
    .erase_go_o(erase_go),
    .sect_o    (sect)
  );

  fse_sect_mem #(.SECT_W(SECT_W), .KEEP_W(KEEP_W)) u_mem (
    .clk_i, .rst_ni,
    .erase_go_i(erase_go),
    .sect_i    (sect),
    .peek_sect_i,
    .peek_off_i,
    .peek_data_o
  );
endmodule

// File: rtl/fse_checker.sv
module fse_checker
  import fse_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 5000,
  parameter int unsigned SECT_W       = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sck_i,
  input logic              sdo_o,
  input logic              busy,
  input logic              wel,
  input logic              cs_rise,
  input logic [SECT_W-1:0] sect,
  input logic [2:0]        prot_lvl_i,
  input logic              prot_bot_i
);
  localparam int unsigned RW = $clog2(ERASE_CYCLES + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  assert_busy_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> run_q == RW'(ERASE_CYCLES));
  assert_wel_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel);
  assert_needs_wel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wel));
  assert_start_on_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(cs_rise));
  assert_unguarded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !sect_guarded(32'(sect), 32'(1 << SECT_W), $past(prot_lvl_i), $past(prot_bot_i)));
  assert_wel_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel) |-> !$past(busy));
  assert_wel_on_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel) |-> $past(cs_rise));
  assert_sdo_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> ($past(cs_ni) || (!$past(sck_i) && $past(sck_i, 2))));
endmodule

bind flash_sector_erase fse_checker #(.ERASE_CYCLES(ERASE_CYCLES), .SECT_W(SECT_W)) u_chk (
  .clk_i, .rst_ni, .cs_ni, .sck_i, .sdo_o,
  .busy, .wel, .cs_rise, .sect,
  .prot_lvl_i, .prot_bot_i
);

// File: tb/flash_sector_erase_tb.sv
module flash_sector_erase_tb;
  localparam int CLK_P   = 10;
  localparam int ERASE_N = 300;
  localparam int SW      = 3;
  localparam int KW      = 3;
  localparam int NS      = 1 << SW;
  localparam int NB      = 1 << (SW + KW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [2:0] lvl = '0;
  logic bot = 1'b0;
  logic [SW-1:0] pk_s = '0;
  logic [KW-1:0] pk_o = '0;
  logic [7:0] pk_d;

  int total = 0, bad = 0;
  int cyc = 0, t_cs = 0;
  bit done = 0;
  logic [7:0] model [NB];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_sector_erase #(.ERASE_CYCLES(ERASE_N), .SECT_W(SW), .KEEP_W(KW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo),
    .prot_lvl_i(lvl), .prot_bot_i(bot), .peek_sect_i(pk_s), .peek_off_i(pk_o),
    .peek_data_o(pk_d));

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    for (int i = 0; i < NB; i++) model[i] = {1'b0, 7'((i * 5 + 3) % 128)};
  endtask

  task automatic cs_start();
    cs_n = 1'b0; tick(2);
  endtask

  task automatic cs_end();
    sck = 1'b0; tick(2);
    cs_n = 1'b1; t_cs = cyc;
    tick(3);
  endtask

  task automatic send_bits(logic [39:0] v, int n);
    for (int i = 0; i < n; i++) begin
      sdi = v[n-1-i]; sck = 1'b0; tick(2);
      sck = 1'b1; tick(2);
    end
  endtask

  task automatic rd_byte(output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; tick(2);
      b = {b[6:0], sdo};
      sck = 1'b1; tick(2);
    end
  endtask

  task automatic cmd(logic [39:0] v, int n);
    cs_start(); send_bits(v, n); cs_end();
  endtask

  task automatic rd_status(output logic [7:0] s);
    cs_start(); send_bits(40'h05, 8); rd_byte(s); cs_end();
  endtask

  task automatic check_mem(string tag);
    for (int i = 0; i < NB; i++) begin
      pk_s = SW'(i >> KW); pk_o = KW'(i);
      #1;
      chk(tag, int'(pk_d), int'(model[i]));
    end
  endtask

  function automatic logic [23:0] mk_addr(int sect, int salt);
    logic [23:0] a;
    a = 24'((salt * 24'h2B7) & 24'hFFF);
    a[SECT_LSB_L +: SW] = SW'(sect);
    a[23:12+SW] = (12 - SW)'(salt * 7 + 1);
    return a;
  endfunction
  localparam int SECT_LSB_L = 12;

  task automatic erase_run(int sect, int salt, string tag);
    logic [7:0] s;
    int polls;
    int el;
    cmd({8'h20, mk_addr(sect, salt)}, 32);
    el = t_cs;
    rd_status(s);
    chk({tag, " R8 busy"}, int'(s), 8'h03);
    polls = 0;
    while (s[0] && polls < 50) begin
      rd_status(s);
      polls++;
    end
    el = t_cs - el;
    chk({tag, " R8 done"}, int'(el >= ERASE_N && el < ERASE_N + 120), 1);
    chk({tag, " R9 wel"}, int'(s), 8'h00);
    for (int k = 0; k < (1 << KW); k++) model[(sect << KW) + k] = 8'hFF;
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] s, s2;
    do_reset();
    // R1 reset state
    rd_status(s);
    chk("R1 status", int'(s), 8'h00);
    check_mem("R1 mem");

    // R6 erase with latch clear
    cmd({8'h20, mk_addr(2, 1)}, 32);
    tick(4);
    rd_status(s);
    chk("R6 status", int'(s), 8'h00);
    check_mem("R6 mem");

    // R2 wrong bit counts, then exact
    cmd(40'h06 >> 1, 7);
    rd_status(s);
    chk("R2 7 bits", int'(s), 8'h00);
    cmd({40'h06, 1'b0}, 9);
    rd_status(s);
    chk("R2 9 bits", int'(s), 8'h00);
    cmd(40'h06, 8);
    rd_status(s);
    chk("R2 set", int'(s), 8'h02);

    // R5 aborted erase, 31 and 33 bits
    cmd({8'h20, mk_addr(3, 2)} >> 1, 31);
    tick(4);
    rd_status(s);
    chk("R5 31 bits", int'(s), 8'h02);
    cmd({8'h20, mk_addr(3, 2), 1'b0}, 33);
    tick(4);
    rd_status(s);
    chk("R5 33 bits", int'(s), 8'h02);
    check_mem("R5 mem");

    // R4 R3 R10 valid erase with repeated status and a second erase while busy
    cmd({8'h20, mk_addr(5, 3)}, 32);
    cs_start(); send_bits(40'h05, 8); rd_byte(s); rd_byte(s2); cs_end();
    chk("R3 first byte", int'(s), 8'h03);
    chk("R3 repeat byte", int'(s2), 8'h03);
    cmd({8'h20, mk_addr(1, 4)}, 32);
    cmd(40'h06, 8);
    s = 8'h01;
    for (int p = 0; p < 50 && s[0]; p++) rd_status(s);
    chk("R10 R9 end status", int'(s), 8'h00);
    for (int k = 0; k < (1 << KW); k++) model[(5 << KW) + k] = 8'hFF;
    check_mem("R4 R10 mem");

    // R7 sweep: every level, side and sector
    for (int lv = 0; lv < 8; lv++) begin
      for (int bt = 0; bt < 2; bt++) begin
        do_reset();
        lvl = 3'(lv); bot = bt[0];
        for (int sc = 0; sc < NS; sc++) begin
          int span;
          bit prot;
          span = (lv == 0) ? 0 : (1 << (lv - 1));
          if (span > NS) span = NS;
          prot = bt ? (sc < span) : (sc >= NS - span);
          cmd(40'h06, 8);
          if (prot) begin
            cmd({8'h20, mk_addr(sc, lv * 16 + bt * 8 + sc)}, 32);
            tick(4);
            rd_status(s);
            chk("R7 R9 refused", int'(s), 8'h02);
          end else begin
            erase_run(sc, lv * 16 + bt * 8 + sc, "R7 R4");
          end
          check_mem("R7 R4 mem");
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule